// File: doc/BRIEF.md
# Bipolar Return-to-Zero Word Serializer

This block takes 32-bit words from an upstream queue and sends each one as 32 serial bits on a complementary pair of return-to-zero lines. The low 31 bits are sent as they arrive. The top bit is replaced either by a computed parity bit or by the word's own bit 31, depending on the configuration inputs, and the parity sense can be set to odd or even.

Every bit has an active half followed by a null half, and consecutive words are separated by a quiet gap. Two line speeds are available and both are timed in whole clock cycles of the single block clock. A self-test path copies the line activity onto two internal receiver feeds: one carries the line pair as sent and the other carries its complement. The external lines keep running while self-test is on.

The upstream queue presents a word through `word_valid` and `word_data`. The block takes the word when transmission is enabled, and acknowledges it with a one-cycle `word_pop` pulse.

Top module: `rz_word_serializer`

## Requirements
- R1: A synchronous `rst` high stops any word in progress. From the next cycle, `line_pos`, `line_neg`, `word_pop` and all loopback outputs are low and stay low until a new word starts. The configuration inputs keep their effect after reset, and the next word uses them without being set again.
- R2: The block may be idle, or at the last cycle of a word gap. If it samples `tx_enable`=1 and `word_valid`=1 at that clock edge, it takes `word_data`, drives `word_pop` high for exactly one cycle after that edge, and shows the first bit on the lines in that same cycle (one clock of latency). `word_pop` is never high unless both inputs were high one cycle earlier.
- R3: During the active half, a 1 bit gives `line_pos`=1 and `line_neg`=0, and a 0 bit gives `line_pos`=0 and `line_neg`=1. Both lines are 0 during every null half, every word gap and while idle. The two lines are never high together, and a high line is always followed by a cycle with the other line low.
- R4: The serial order is `word_data[0]` first up to `word_data[30]`, and then the bit-32 value described in R8 and R9 as the 32nd and last bit.
- R5: With `speed_lo`=0, every bit has 5 active cycles and then 5 null cycles, and the gap after the word is 40 cycles.
- R6: With `speed_lo`=1, every bit has 40 active cycles and then 40 null cycles, and the gap after the word is 320 cycles.
- R7: `speed_lo` is sampled only when a word is taken. Changing it during a word does not change the timing of that word, including its gap.
- R8: When parity is selected, the 32nd bit makes the number of ones in all 32 sent bits odd if `par_even`=0, and even if `par_even`=1.
- R9: If `par_force`=1, the 32nd bit is parity. If `par_force`=0, `par_enable`=1 selects parity and `par_enable`=0 sends `word_data[31]`. The configuration is sampled when the word is taken.
- R10: If a word is waiting and `tx_enable`=1 at the last gap cycle, the next word's first bit follows directly, so the lines are low for exactly the gap length between words. If `tx_enable`=0 while the block is idle, no word is taken, `word_pop` stays low and the lines stay low.
- R11: With `selftest`=1, `lb1_pos`/`lb1_neg` equal `line_pos`/`line_neg`, and `lb2_pos`/`lb2_neg` equal `line_neg`/`line_pos` (the complement). With `selftest`=0, all four loopback outputs are 0. The external lines behave the same in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; all timing counts its cycles |
| rst | input | 1 | Synchronous active-high master reset |
| tx_enable | input | 1 | Allows words to be taken from the queue |
| word_valid | input | 1 | Queue holds a word |
| word_data | input | 32 | Head word of the queue; bit 31 is the optional data bit 32 |
| word_pop | output | 1 | One-cycle pulse when the head word has been taken |
| speed_lo | input | 1 | 1 selects the slow line rate, 0 selects the fast rate |
| par_even | input | 1 | Parity sense: 0 gives odd parity, 1 gives even parity |
| par_enable | input | 1 | Selects parity for bit 32 when `par_force` is low |
| par_force | input | 1 | 1 always places parity in bit 32 |
| selftest | input | 1 | Enables the internal loopback feeds |
| line_pos | output | 1 | Positive return-to-zero line |
| line_neg | output | 1 | Negative return-to-zero line |
| lb1_pos | output | 1 | Loopback feed 1, positive rail (as sent) |
| lb1_neg | output | 1 | Loopback feed 1, negative rail (as sent) |
| lb2_pos | output | 1 | Loopback feed 2, positive rail (complemented) |
| lb2_neg | output | 1 | Loopback feed 2, negative rail (complemented) |

## Verification
The hardest case to reach from the ports is a change of `speed_lo` inside a word in progress. The speed must be held from the start of the word through to the end of its gap, and this is visible only in the cycle count of later bits. The stimulus therefore flips the speed input after the first bits of both a fast and a slow word, and compares every later sample against the timing captured at the start of the word.

Two other cases are exercised directly. A reset is applied in the middle of a slow word. Three queued words are sent back to back, which checks that each new word is taken at the gap boundary. Around these directed cases, random words and random parity, bit-32 and loopback settings are checked sample by sample against a bench model of the line waveform.

// File: rtl/rz_pkg.sv
package rz_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MARK = 2'd1,
    S_NULL = 2'd2,
    S_GAP  = 2'd3
  } rz_state_t;
endpackage

// File: rtl/rz_bit32_sel.sv
module rz_bit32_sel #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic              par_even,
  input  logic              par_enable,
  input  logic              par_force,
  output logic              last_bit
);
  localparam int DATA_W = WORD_W - 1;

  logic ones_odd;
  logic par_bit;
  logic use_par;

  always_comb begin
    ones_odd = ^word_in[DATA_W-1:0];
    // odd sense: total ones odd; even sense: total ones even
    par_bit  = par_even ? ones_odd : ~ones_odd;
    use_par  = par_force | par_enable;
    last_bit = use_par ? par_bit : word_in[WORD_W-1];
  end
endmodule

// File: rtl/rz_loopback.sv
module rz_loopback (
  input  logic enable,
  input  logic tx_pos,
  input  logic tx_neg,
  output logic rx1_pos,
  output logic rx1_neg,
  output logic rx2_pos,
  output logic rx2_neg
);
  always_comb begin
    rx1_pos = enable & tx_pos;
    rx1_neg = enable & tx_neg;
    rx2_pos = enable & tx_neg;
    rx2_neg = enable & tx_pos;
  end
endmodule

// File: rtl/rz_word_serializer.sv
module rz_word_serializer #(
  parameter int WORD_W  = 32,
  parameter int HI_HALF = 5,
  parameter int HI_GAP  = 40,
  parameter int LO_HALF = 40,
  parameter int LO_GAP  = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_enable,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_pop,
  input  logic              speed_lo,
  input  logic              par_even,
  input  logic              par_enable,
  input  logic              par_force,
  input  logic              selftest,
  output logic              line_pos,
  output logic              line_neg,
  output logic              lb1_pos,
  output logic              lb1_neg,
  output logic              lb2_pos,
  output logic              lb2_neg
);
  import rz_pkg::*;

  localparam int DATA_W  = WORD_W - 1;
  localparam int MAX_A   = (HI_HALF > HI_GAP) ? HI_HALF : HI_GAP;
  localparam int MAX_B   = (LO_HALF > LO_GAP) ? LO_HALF : LO_GAP;
  localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int IDX_W   = $clog2(WORD_W);

  localparam logic [CNT_W-1:0] HI_HALF_END = CNT_W'(HI_HALF - 1);
  localparam logic [CNT_W-1:0] HI_GAP_END  = CNT_W'(HI_GAP - 1);
  localparam logic [CNT_W-1:0] LO_HALF_END = CNT_W'(LO_HALF - 1);
  localparam logic [CNT_W-1:0] LO_GAP_END  = CNT_W'(LO_GAP - 1);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(WORD_W - 1);

  rz_state_t          state;
  logic [WORD_W-1:0]  shreg;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   bidx;
  logic               spd;
  logic               last_bit;
  logic [WORD_W-1:0]  load_word;
  logic [CNT_W-1:0]   half_end;
  logic [CNT_W-1:0]   gap_end;
  logic               take;

  rz_bit32_sel #(.WORD_W(WORD_W)) u_bit32 (
    .word_in    (word_data),
    .par_even   (par_even),
    .par_enable (par_enable),
    .par_force  (par_force),
    .last_bit   (last_bit)
  );

  rz_loopback u_loop (
    .enable  (selftest),
    .tx_pos  (line_pos),
    .tx_neg  (line_neg),
    .rx1_pos (lb1_pos),
    .rx1_neg (lb1_neg),
    .rx2_pos (lb2_pos),
    .rx2_neg (lb2_neg)
  );

  always_comb begin
    load_word = {last_bit, word_data[DATA_W-1:0]};
    half_end  = spd ? LO_HALF_END : HI_HALF_END;
    gap_end   = spd ? LO_GAP_END : HI_GAP_END;
    take      = tx_enable && word_valid &&
                ((state == S_IDLE) || ((state == S_GAP) && (cnt == gap_end)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      bidx     <= '0;
      spd      <= 1'b0;
      word_pop <= 1'b0;
      line_pos <= 1'b0;
      line_neg <= 1'b0;
    end else begin
      word_pop <= take;
      if (take) begin
        shreg    <= load_word;
        spd      <= speed_lo;
        cnt      <= '0;
        bidx     <= '0;
        state    <= S_MARK;
        line_pos <= load_word[0];
        line_neg <= ~load_word[0];
      end else begin
        case (state)
          S_MARK: begin
            if (cnt == half_end) begin
              cnt      <= '0;
              state    <= S_NULL;
              line_pos <= 1'b0;
              line_neg <= 1'b0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_NULL: begin
            if (cnt == half_end) begin
              cnt <= '0;
              if (bidx == LAST_IDX) begin
                state <= S_GAP;
              end else begin
                bidx     <= bidx + IDX_W'(1);
                shreg    <= {1'b0, shreg[WORD_W-1:1]};
                state    <= S_MARK;
                line_pos <= shreg[1];
                line_neg <= ~shreg[1];
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          S_GAP: begin
            if (cnt == gap_end) begin
              cnt   <= '0;
              state <= S_IDLE;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: begin
            cnt      <= '0;
            line_pos <= 1'b0;
            line_neg <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rz_checker.sv
module rz_checker (
  input logic clk,
  input logic rst,
  input logic tx_enable,
  input logic word_valid,
  input logic word_pop,
  input logic selftest,
  input logic line_pos,
  input logic line_neg,
  input logic lb1_pos,
  input logic lb1_neg,
  input logic lb2_pos,
  input logic lb2_neg
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!line_pos && !line_neg && !word_pop));

  assert_pop_cause_R2: assert property (@(posedge clk) disable iff (rst)
    word_pop |-> $past(tx_enable && word_valid));

  assert_pop_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    word_pop |=> !word_pop);

  assert_rails_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(line_pos && line_neg));

  assert_rz_return_pos_R3: assert property (@(posedge clk) disable iff (rst)
    line_pos |=> !line_neg);

  assert_rz_return_neg_R3: assert property (@(posedge clk) disable iff (rst)
    line_neg |=> !line_pos);

  assert_loop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !selftest |-> !(lb1_pos || lb1_neg || lb2_pos || lb2_neg));

  assert_loop_follow_R11: assert property (@(posedge clk) disable iff (rst)
    (selftest && line_pos) |-> (lb1_pos && lb2_neg && !lb1_neg && !lb2_pos));
endmodule

bind rz_word_serializer rz_checker u_rz_checker (
  .clk        (clk),
  .rst        (rst),
  .tx_enable  (tx_enable),
  .word_valid (word_valid),
  .word_pop   (word_pop),
  .selftest   (selftest),
  .line_pos   (line_pos),
  .line_neg   (line_neg),
  .lb1_pos    (lb1_pos),
  .lb1_neg    (lb1_neg),
  .lb2_pos    (lb2_pos),
  .lb2_neg    (lb2_neg)
);

// File: tb/tb_rz_word_serializer.sv
`timescale 1ns/1ps
module tb_rz_word_serializer;
  logic clk = 1'b0;
  logic rst, tx_enable, word_valid, word_pop;
  logic [31:0] word_data;
  logic speed_lo, par_even, par_enable, par_force, selftest;
  logic line_pos, line_neg, lb1_pos, lb1_neg, lb2_pos, lb2_neg;

  always #2 clk = ~clk;

  rz_word_serializer dut (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .word_valid(word_valid),
    .word_data(word_data), .word_pop(word_pop), .speed_lo(speed_lo),
    .par_even(par_even), .par_enable(par_enable), .par_force(par_force),
    .selftest(selftest), .line_pos(line_pos), .line_neg(line_neg),
    .lb1_pos(lb1_pos), .lb1_neg(lb1_neg), .lb2_pos(lb2_pos), .lb2_neg(lb2_neg)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] qmem [0:63];
  int q_head = 0;
  int q_tail = 0;
  int pops = 0;

  assign word_valid = (q_head != q_tail);
  assign word_data  = qmem[q_head[5:0]];

  always @(negedge clk) begin
    if (word_pop) begin
      q_head <= q_head + 1;
      pops   <= pops + 1;
    end
  end

  task automatic push(input logic [31:0] w);
    qmem[q_tail[5:0]] = w;
    q_tail = q_tail + 1;
  endtask

  function automatic logic exp_last(input logic [31:0] w);
    logic p;
    p = ^w[30:0];
    if (par_force || par_enable) return par_even ? p : ~p;
    return w[31];
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // one sample against expected rails; returns 1 on match
  function automatic bit sample_ok(input logic ep, input logic en);
    logic l1p, l1n, l2p, l2n;
    l1p = selftest & ep; l1n = selftest & en;
    l2p = selftest & en; l2n = selftest & ep;
    return (line_pos === ep) && (line_neg === en) && (lb1_pos === l1p) &&
           (lb1_neg === l1n) && (lb2_pos === l2p) && (lb2_neg === l2n);
  endfunction

  // Called at a negedge just before the posedge that takes the word.
  task automatic check_word(input logic [31:0] w, input bit flip, input string req);
    logic [31:0] e;
    int half, gap;
    bit bad;
    string msg;
    bad = 0;
    e = {exp_last(w), w[30:0]};
    half = speed_lo ? 40 : 5;
    gap  = speed_lo ? 320 : 40;
    for (int i = 0; i < 32; i++) begin
      if (flip && i == 2) speed_lo = ~speed_lo;
      for (int c = 0; c < half; c++) begin
        @(negedge clk);
        if (!bad && !sample_ok(e[i], ~e[i])) begin
          bad = 1;
          msg = $sformatf("word %h bit %0d mark cyc %0d: actual p/n %b%b lb %b%b%b%b expected p/n %b%b",
                          w, i, c, line_pos, line_neg, lb1_pos, lb1_neg, lb2_pos, lb2_neg, e[i], ~e[i]);
        end
      end
      for (int c = 0; c < half; c++) begin
        @(negedge clk);
        if (!bad && !sample_ok(1'b0, 1'b0)) begin
          bad = 1;
          msg = $sformatf("word %h bit %0d null cyc %0d: actual p/n %b%b expected 00",
                          w, i, c, line_pos, line_neg);
        end
      end
    end
    for (int c = 0; c < gap; c++) begin
      @(negedge clk);
      if (!bad && !sample_ok(1'b0, 1'b0)) begin
        bad = 1;
        msg = $sformatf("word %h gap cyc %0d: actual p/n %b%b expected 00", w, c, line_pos, line_neg);
      end
    end
    check(!bad, req, msg);
  endtask

  task automatic idle_check(input int n, input string req);
    bit bad;
    bad = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (line_pos || line_neg || word_pop || lb1_pos || lb1_neg || lb2_pos || lb2_neg) bad = 1;
    end
    check(!bad, req, $sformatf("idle outputs actual p/n/pop %b%b%b expected 000",
                               line_pos, line_neg, word_pop));
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int pushed;
    logic [31:0] w;
    void'($urandom(32'h5EED1234));
    rst = 1; tx_enable = 0; speed_lo = 0; par_even = 0;
    par_enable = 0; par_force = 0; selftest = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    idle_check(3, "R1");

    // R10: disabled, word waiting, nothing taken
    push(32'hA5A5_0F0F); pushed = 1;
    idle_check(20, "R10");
    check(pops == 0, "R10", $sformatf("pops actual %0d expected 0", pops));

    // R2 R3 R4 R5: enable, bit 32 carries data (R9)
    tx_enable = 1;
    check_word(32'hA5A5_0F0F, 0, "R2 R3 R4 R5");
    push(32'h0000_0001); pushed++;
    check_word(32'h0000_0001, 0, "R9 data bit 32 = 0");
    push(32'h8000_0003); pushed++;
    check_word(32'h8000_0003, 0, "R9 data bit 32 = 1");

    // R8 parity senses
    par_enable = 1;
    push(32'h0000_0007); pushed++;
    check_word(32'h0000_0007, 0, "R8 odd");
    par_even = 1;
    push(32'h0000_0007); pushed++;
    check_word(32'h0000_0007, 0, "R8 even");
    par_enable = 0; par_force = 1; par_even = 0;
    push(32'h8000_0000); pushed++;
    check_word(32'h8000_0000, 0, "R9 force parity");
    par_force = 0;

    // R11 loopback
    selftest = 1;
    push(32'h1234_5678); pushed++;
    check_word(32'h1234_5678, 0, "R11");
    selftest = 0;

    // R10 back to back words
    push(32'h0F0F_F0F0); push(32'h7FFF_FFFF); push(32'h4000_0001); pushed += 3;
    check_word(32'h0F0F_F0F0, 0, "R10 first");
    check_word(32'h7FFF_FFFF, 0, "R10 second");
    check_word(32'h4000_0001, 0, "R10 third");

    // R7 speed flips mid word, both directions; R6 slow timing
    push(32'h00C3_3C00); pushed++;
    check_word(32'h00C3_3C00, 1, "R7 fast held");
    check(speed_lo == 1, "R7", "flip setup");
    push(32'h3355_AACC); pushed++;
    check_word(32'h3355_AACC, 1, "R6 R7 slow held");
    speed_lo = 1;
    push(32'h0000_FFFF); pushed++;
    check_word(32'h0000_FFFF, 0, "R6");

    // R1 reset mid word
    push(32'h5555_5555); pushed++;
    repeat (150) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check(!line_pos && !line_neg, "R1",
          $sformatf("after reset p/n actual %b%b expected 00", line_pos, line_neg));
    @(negedge clk);
    rst = 0;
    idle_check(30, "R1");
    par_enable = 1; par_even = 1; speed_lo = 0;
    push(32'h0000_0003); pushed++;
    check_word(32'h0000_0003, 0, "R1 config kept");

    // random words and settings
    for (int k = 0; k < 24; k++) begin
      par_even   = $urandom() & 1;
      par_enable = $urandom() & 1;
      par_force  = (($urandom() % 4) == 0);
      selftest   = (($urandom() % 3) == 0);
      w = $urandom();
      push(w); pushed++;
      check_word(w, 0, "R4 R8 R9 random");
    end
    selftest = 0;
    idle_check(5, "R10");
    check(pops == pushed, "R2", $sformatf("pops actual %0d expected %0d", pops, pushed));
    summary();
  end
endmodule